// File: doc/BRIEF.md
# SPI Master with Per-Select Word Length and Chip-Select Hold

This block is a serial peripheral interface master serving four slaves. A host programs a small set of per-slave settings: word length, clock divider, clock polarity, clock phase and a hold option. It then writes transmit words one at a time through a single holding register. The active slave is chosen by a two-bit select input that the block samples when a word moves from the holding register into the shifter. Each finished word lands right-aligned in a read data register and raises receive-ready.

Chip-select release is controlled per word. A slave without the hold option is released at the end of every word. A slave with the hold option stays selected through idle gaps between words. It is released when its word carries the last-transfer flag, and it loses the select when a word for another slave starts. The serial clock stays at its reset level until the first word starts, so programming the block never produces stray clock edges.

Top module: `spi_hold_master`

## Requirements
- R1: Each slave's word length can be set from 8 to 16 bits. Write values outside that range are clamped to it. MOSI sends `txData[15:0]` most significant bit first, starting from bit length-1. The received word appears in `rxData` right-aligned, with zeros above the word length.
- R2: A divider value D from 1 upward makes every SCLK phase last D system clocks. A word of B bits gives exactly B SCLK pulses and keeps its chip select low for exactly 2·B·D clocks when no hold applies. This holds for odd B at D=1.
- R3: With the hold option set for a slave, that slave's chip select stays low after its word ends, through any idle time, until a word with the last flag ends or a word for a different slave starts.
- R4: Bit 24 of `txData` is the last-transfer flag. The chip select goes high at the end of a word carrying it. Without the hold option, the chip select goes high at the end of every word.
- R5: `txReady` is high while the holding register is empty. It rises again on the cycle a word moves into the shifter, including back-to-back and idle-separated words to the same slave. Writes while it is low are ignored, and no word is ever sent twice.
- R6: `txEmpty` is high only when both the holding register and the shifter are empty.
- R7: `xferSize` reports the word length of the slave picked by `fixedSel`, never the length of slave 0 when another slave is picked.
- R8: The chip-select outputs are active low with at most one low at a time. Slave k drives `csN[k]`, picked by `fixedSel` = k when a word starts.
- R9: SCLK stays low from reset until the first word starts, whatever settings are written in the meantime.
- R10: Between words SCLK rests at the slave's polarity setting. With phase 0 data is sampled on the leading edge; with phase 1 data is sampled on the trailing edge.
- R11: A divider value of 0 disables the slave. While the picked slave has divider 0, no word starts, its chip select stays high and `txReady` stays low.
- R12: `rxReady` is low after reset, rises when a word ends, and is cleared by `rxRd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Write strobe for one slave's settings |
| cfgIdx | input | 2 | Slave whose settings are written |
| cfgBits | input | 5 | Word length, 8 to 16 |
| cfgDiv | input | 8 | Clock divider, 0 disables |
| cfgCpol | input | 1 | SCLK idle level |
| cfgCpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfgHold | input | 1 | Keep chip select low between words |
| fixedSel | input | 2 | Slave used for the next word |
| txWe | input | 1 | Transmit write strobe |
| txData | input | 32 | Bits 15:0 payload, bit 24 last-transfer flag |
| txReady | output | 1 | Holding register empty |
| txEmpty | output | 1 | Holding register and shifter both empty |
| rxRd | input | 1 | Acknowledge of the received word |
| rxData | output | 16 | Last received word, right-aligned |
| rxReady | output | 1 | A received word is waiting |
| xferSize | output | 5 | Word length of the picked slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 4 | Active-low chip selects |

## Verification
Wrong internal state shows up at the ports within one word. A half-phase counter off by one yields a pulse count or chip-select low time that differs from B and 2·B·D as soon as that word ends. A holding-register flag that fails to clear shows up as `txReady` staying low on the cycle after the load, or as a word appearing twice in the slave model's capture queue. A chip-select state that mishandles hold or the last flag is visible at `csN` in the idle cycles right after the word ends. The slave model rebuilds every MOSI word and feeds known MISO patterns, so a misaligned shifter fails the comparison on the first word of the affected length.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  parameter int NUM_CS   = 4;
  parameter int CS_W     = $clog2(NUM_CS);
  parameter int MIN_BITS = 8;
  parameter int MAX_BITS = 16;
  parameter int CNT_W    = $clog2(MAX_BITS + 1);
  parameter int HALF_W   = CNT_W + 1;
  parameter int DIV_W    = 8;
  parameter int TX_W     = 32;
  parameter int LAST_POS = 24;

  typedef struct packed {
    logic [CNT_W-1:0] bits;
    logic [DIV_W-1:0] div;
    logic             cpol;
    logic             cpha;
    logic             hold;
  } csCfg_t;

  typedef struct packed {
    logic capture;
    logic load;
    logic toggle;
    logic shiftOut;
    logic sample;
    logic finish;
  } dpStrobe_t;

  typedef enum logic {ST_IDLE, ST_SHIFT} xferState_t;

  function automatic logic [CNT_W-1:0] clampBits(input logic [CNT_W-1:0] b);
    if (b < CNT_W'(MIN_BITS)) return CNT_W'(MIN_BITS);
    if (b > CNT_W'(MAX_BITS)) return CNT_W'(MAX_BITS);
    return b;
  endfunction
endpackage

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
  import spi_hold_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CS_W-1:0]   cfgIdx,
  input  logic [CNT_W-1:0]  cfgBits,
  input  logic [DIV_W-1:0]  cfgDiv,
  input  logic              cfgCpol,
  input  logic              cfgCpha,
  input  logic              cfgHold,
  input  logic [CS_W-1:0]   fixedSel,
  input  logic              txWe,
  input  logic              txLast,
  input  logic              rxRd,
  output dpStrobe_t         strb,
  output csCfg_t            selCfg,
  output logic [NUM_CS-1:0] csN,
  output logic              txReady,
  output logic              txEmpty,
  output logic              rxReady,
  output logic [CNT_W-1:0]  xferSize
);
  csCfg_t            cfgTab [NUM_CS];
  csCfg_t            curCfg;
  xferState_t        state;
  logic              holdFull, holdLast, curLast;
  logic [DIV_W-1:0]  divCnt;
  logic [HALF_W-1:0] halfCnt;
  logic [CS_W-1:0]   csIdx;
  logic              csOn;
  logic              halfEnd, lastHalf, busy;

  // per-slave settings table
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CS; i++) begin
        cfgTab[i] <= '{bits: CNT_W'(MIN_BITS), div: '0, cpol: 1'b0, cpha: 1'b0, hold: 1'b0};
      end
    end else if (cfgWe) begin
      for (int i = 0; i < NUM_CS; i++) begin
        if (cfgIdx == CS_W'(i)) begin
          cfgTab[i] <= '{bits: clampBits(cfgBits), div: cfgDiv, cpol: cfgCpol,
                         cpha: cfgCpha, hold: cfgHold};
        end
      end
    end
  end

  assign selCfg   = cfgTab[fixedSel];
  assign xferSize = selCfg.bits;
  assign busy     = (state == ST_SHIFT);

  assign halfEnd  = busy && (divCnt == curCfg.div - 1'b1);
  assign lastHalf = (halfCnt == HALF_W'({curCfg.bits, 1'b0}) - 1'b1);

  // strobes toward the datapath
  always_comb begin
    strb          = '0;
    strb.capture  = txWe && !holdFull;
    strb.load     = !busy && holdFull && (selCfg.div != '0);
    strb.toggle   = halfEnd;
    strb.finish   = halfEnd && lastHalf;
    strb.sample   = halfEnd && (halfCnt[0] == curCfg.cpha);
    if (curCfg.cpha) strb.shiftOut = halfEnd && !halfCnt[0] && (halfCnt != '0);
    else             strb.shiftOut = halfEnd && halfCnt[0] && !lastHalf;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      curCfg   <= '0;
      holdFull <= 1'b0;
      holdLast <= 1'b0;
      curLast  <= 1'b0;
      divCnt   <= '0;
      halfCnt  <= '0;
      csIdx    <= '0;
      csOn     <= 1'b0;
      rxReady  <= 1'b0;
    end else begin
      if (strb.capture) begin
        holdFull <= 1'b1;
        holdLast <= txLast;
      end
      if (strb.load) begin
        state    <= ST_SHIFT;
        curCfg   <= selCfg;
        curLast  <= holdLast;
        holdFull <= 1'b0;
        divCnt   <= '0;
        halfCnt  <= '0;
        csIdx    <= fixedSel;
        csOn     <= 1'b1;
      end else if (busy) begin
        if (halfEnd) begin
          divCnt <= '0;
          if (lastHalf) begin
            state <= ST_IDLE;
            if (!curCfg.hold || curLast) csOn <= 1'b0;
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
      if (strb.finish)  rxReady <= 1'b1;
      else if (rxRd)    rxReady <= 1'b0;
    end
  end

  assign txReady = !holdFull;
  assign txEmpty = !holdFull && !busy;

  for (genvar g = 0; g < NUM_CS; g++) begin : gCs
    assign csN[g] = !(csOn && (csIdx == CS_W'(g)));
  end
endmodule

// File: rtl/spi_hold_dp.sv
module spi_hold_dp
  import spi_hold_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strb,
  input  csCfg_t              selCfg,
  input  logic [MAX_BITS-1:0] txWord,
  input  logic                miso,
  output logic                sclk,
  output logic                mosi,
  output logic [MAX_BITS-1:0] rxData
);
  logic [MAX_BITS-1:0] holdData, txShift, rxShift, rxNext;
  logic [CNT_W-1:0]    shamt;

  assign shamt  = CNT_W'(MAX_BITS) - selCfg.bits;
  assign rxNext = strb.sample ? {rxShift[MAX_BITS-2:0], miso} : rxShift;
  assign mosi   = txShift[MAX_BITS-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdData <= '0;
      txShift  <= '0;
      rxShift  <= '0;
      rxData   <= '0;
      sclk     <= 1'b0;
    end else begin
      if (strb.capture) holdData <= txWord;
      if (strb.load) begin
        txShift <= holdData << shamt;
        rxShift <= '0;
        sclk    <= selCfg.cpol;
      end else begin
        if (strb.toggle)   sclk    <= ~sclk;
        if (strb.shiftOut) txShift <= txShift << 1;
        rxShift <= rxNext;
        if (strb.finish)   rxData  <= rxNext;
      end
    end
  end
endmodule

// File: rtl/spi_hold_master.sv
module spi_hold_master
  import spi_hold_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [CS_W-1:0]     cfgIdx,
  input  logic [CNT_W-1:0]    cfgBits,
  input  logic [DIV_W-1:0]    cfgDiv,
  input  logic                cfgCpol,
  input  logic                cfgCpha,
  input  logic                cfgHold,
  input  logic [CS_W-1:0]     fixedSel,
  input  logic                txWe,
  input  logic [TX_W-1:0]     txData,
  output logic                txReady,
  output logic                txEmpty,
  input  logic                rxRd,
  output logic [MAX_BITS-1:0] rxData,
  output logic                rxReady,
  output logic [CNT_W-1:0]    xferSize,
  output logic                sclk,
  output logic                mosi,
  input  logic                miso,
  output logic [NUM_CS-1:0]   csN
);
  dpStrobe_t strb;
  csCfg_t    selCfg;
  logic      unusedTxBits;

  assign unusedTxBits = ^{txData[TX_W-1:LAST_POS+1], txData[LAST_POS-1:MAX_BITS]};

  spi_hold_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgBits(cfgBits),
    .cfgDiv(cfgDiv), .cfgCpol(cfgCpol), .cfgCpha(cfgCpha), .cfgHold(cfgHold),
    .fixedSel(fixedSel), .txWe(txWe), .txLast(txData[LAST_POS]), .rxRd(rxRd),
    .strb(strb), .selCfg(selCfg), .csN(csN), .txReady(txReady),
    .txEmpty(txEmpty), .rxReady(rxReady), .xferSize(xferSize)
  );

  spi_hold_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .selCfg(selCfg),
    .txWord(txData[MAX_BITS-1:0]), .miso(miso), .sclk(sclk), .mosi(mosi),
    .rxData(rxData)
  );
endmodule

// File: rtl/spi_hold_master_chk.sv
module spi_hold_master_chk
  import spi_hold_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CS-1:0] csN,
  input logic              sclk,
  input logic              txReady,
  input logic              txEmpty,
  input logic              rxRd,
  input logic              rxReady,
  input dpStrobe_t         strb
);
  logic seenCs;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              seenCs <= 1'b0;
    else if (csN != '1)     seenCs <= 1'b1;
  end

  assert_cs_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~csN) <= 1);

  assert_sclk_framed_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sclk) |-> (csN != '1 || $past(csN) != '1));

  assert_sclk_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!seenCs && csN == '1) |-> (sclk == 1'b0));

  assert_txready_back_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> txReady);

  assert_empty_implies_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> txReady);

  assert_rx_clear_R12: assert property (@(posedge clk) disable iff (!rstN)
    (rxRd && !strb.finish) |=> !rxReady);
endmodule

bind spi_hold_master spi_hold_master_chk chk_i (
  .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .txReady(txReady),
  .txEmpty(txEmpty), .rxRd(rxRd), .rxReady(rxReady), .strb(strb)
);

// File: tb/spi_hold_master_tb_top.sv
module spi_hold_master_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgIdx = '0;
  logic [4:0]  cfgBits = 5'd8;
  logic [7:0]  cfgDiv = '0;
  logic        cfgCpol = 1'b0, cfgCpha = 1'b0, cfgHold = 1'b0;
  logic [1:0]  fixedSel = '0;
  logic        txWe = 1'b0;
  logic [31:0] txData = '0;
  logic        txReady, txEmpty, rxReady, sclk, mosi;
  logic        rxRd = 1'b0;
  logic [15:0] rxData;
  logic [4:0]  xferSize;
  logic [3:0]  csN;
  logic        misoCur = 1'b0;

  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  spi_hold_master dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgBits(cfgBits),
    .cfgDiv(cfgDiv), .cfgCpol(cfgCpol), .cfgCpha(cfgCpha), .cfgHold(cfgHold),
    .fixedSel(fixedSel), .txWe(txWe), .txData(txData), .txReady(txReady),
    .txEmpty(txEmpty), .rxRd(rxRd), .rxData(rxData), .rxReady(rxReady),
    .xferSize(xferSize), .sclk(sclk), .mosi(mosi), .miso(misoCur), .csN(csN)
  );

  // ---------------- slave model ----------------
  bit          slaveEn = 0;
  int          sBits = 8;
  bit          sCpol = 0, sCpha = 0;
  int          sCnt = 0, sWordIdx = 0, pulses = 0;
  logic [15:0] sCap = '0;
  logic [15:0] gotQ[$];
  int          csCycles = 0;

  function automatic logic [15:0] misoPat(input int idx);
    return 16'hA5C3 ^ 16'(idx * 16'h1F1);
  endfunction

  function automatic logic [15:0] maskOf(input int b);
    return 16'((32'd1 << b) - 1);
  endfunction

  always @(sclk) begin
    if (slaveEn && rstN) begin
      logic [15:0] p;
      if (sclk != sCpol) pulses++;
      if ((sclk != sCpol) == (sCpha == 1'b0)) begin
        sCap = {sCap[14:0], mosi};
        sCnt++;
        if (sCnt == sBits) begin
          gotQ.push_back(sCap & maskOf(sBits));
          sCap = '0;
          sCnt = 0;
          sWordIdx++;
        end
        #2;
        p = misoPat(sWordIdx);
        misoCur = p[sBits-1-sCnt];
      end
    end
  end

  always @(posedge clk) if (csN != 4'hF) csCycles++;

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input int idx, input int bits, input int div,
                          input bit cpol, input bit cpha, input bit hold);
    @(negedge clk);
    cfgWe = 1; cfgIdx = 2'(idx); cfgBits = 5'(bits); cfgDiv = 8'(div);
    cfgCpol = cpol; cfgCpha = cpha; cfgHold = hold;
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic slaveSetup(input int bits, input bit cpol, input bit cpha);
    logic [15:0] p;
    sBits = bits; sCpol = cpol; sCpha = cpha;
    sCnt = 0; sWordIdx = 0; pulses = 0; sCap = '0;
    gotQ.delete();
    p = misoPat(0);
    misoCur = p[bits-1];
    csCycles = 0;
  endtask

  task automatic writeWord(input int cs, input logic [15:0] d, input bit last);
    fixedSel = 2'(cs);
    for (int i = 0; i < 5000 && !txReady; i++) @(negedge clk);
    txData = {7'b0, last, 8'h5A, d};
    txWe = 1;
    @(negedge clk);
    txWe = 0;
  endtask

  task automatic waitEmpty();
    for (int i = 0; i < 5000 && !txEmpty; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic oneWord(input int cs, input int bits, input int div, input bit cpol,
                         input bit cpha, input logic [15:0] d, input string tag);
    cfgWrite(cs, bits, div, cpol, cpha, 0);
    slaveSetup(bits, cpol, cpha);
    writeWord(cs, d, 0);
    waitEmpty();
    check(gotQ.size() == 1, {tag, " R1 word count"}, gotQ.size(), 1);
    if (gotQ.size() == 1)
      check(gotQ[0] == (d & maskOf(bits)), {tag, " R1 mosi word"}, gotQ[0], d & maskOf(bits));
    check(rxData == (misoPat(0) & maskOf(bits)), {tag, " R1 rx word"}, rxData,
          misoPat(0) & maskOf(bits));
    check(pulses == bits, {tag, " R2 pulse count"}, pulses, bits);
    check(csCycles == 2 * bits * div, {tag, " R2 cs low cycles"}, csCycles, 2 * bits * div);
    check(csN == 4'hF, {tag, " R4 release without hold"}, csN, 4'hF);
    check(sclk == cpol, {tag, " R10 idle level"}, sclk, cpol);
    check(rxReady == 1'b1, {tag, " R12 rxReady set"}, rxReady, 1);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    void'($urandom(32'd4177));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // reset state
    check(csN == 4'hF, "R8 reset csN", csN, 4'hF);
    check(sclk == 1'b0, "R9 reset sclk", sclk, 0);
    check(txReady && txEmpty, "R6 reset tx flags", {txReady, txEmpty}, 3);
    check(rxReady == 1'b0, "R12 reset rxReady", rxReady, 0);

    // R9: programming with high polarity must not move SCLK
    for (int i = 0; i < 4; i++) begin
      cfgWrite(i, 8 + i, 1 + i, 1, i % 2, 0);
      check(sclk == 1'b0, "R9 sclk quiet while programming", sclk, 0);
    end

    // R7 size follows picked slave
    cfgWrite(0, 10, 1, 0, 0, 0);
    cfgWrite(1, 8, 2, 0, 0, 0);
    fixedSel = 2'd1; @(negedge clk);
    check(xferSize == 5'd8, "R7 size of slave 1", xferSize, 8);
    fixedSel = 2'd0; @(negedge clk);
    check(xferSize == 5'd10, "R7 size of slave 0", xferSize, 10);
    cfgWrite(2, 3, 1, 0, 0, 0);
    fixedSel = 2'd2; @(negedge clk);
    check(xferSize == 5'd8, "R1 clamp low length", xferSize, 8);
    cfgWrite(2, 25, 1, 0, 0, 0);
    @(negedge clk);
    check(xferSize == 5'd16, "R1 clamp high length", xferSize, 16);
    for (int i = 1; i < 4; i++) cfgWrite(i, 8, 1, 0, 0, 0);

    // R2 every length at divider 1, odd and even
    slaveEn = 1;
    for (int b = 8; b <= 16; b++) oneWord(0, b, 1, 0, 0, 16'hC3A5 ^ 16'(b * 77), "div1");
    oneWord(1, 11, 3, 0, 0, 16'h0F0F, "div3");

    // R12 clear
    @(negedge clk); rxRd = 1; @(negedge clk); rxRd = 0;
    check(rxReady == 1'b0, "R12 rxRd clears", rxReady, 0);

    // R3/R4 hold on slave 1
    cfgWrite(1, 12, 2, 0, 0, 1);
    slaveSetup(12, 0, 0);
    writeWord(1, 16'h0ABC, 0); waitEmpty();
    repeat (20) @(negedge clk);
    check(csN == 4'b1101, "R3 held through idle", csN, 4'b1101);
    writeWord(1, 16'h0123, 0); waitEmpty();
    check(csN == 4'b1101, "R3 held after second word", csN, 4'b1101);
    writeWord(1, 16'h0456, 1); waitEmpty();
    check(csN == 4'hF, "R4 last flag releases", csN, 4'hF);
    check(gotQ.size() == 3, "R3 held word count", gotQ.size(), 3);
    if (gotQ.size() == 3)
      check(gotQ[0] == 16'hABC && gotQ[1] == 16'h123 && gotQ[2] == 16'h456,
            "R3 held words", gotQ[2], 16'h456);

    // R3/R8 switching slaves drops the held one
    slaveSetup(12, 0, 0);
    writeWord(1, 16'h0777, 0); waitEmpty();
    check(csN == 4'b1101, "R3 held before switch", csN, 4'b1101);
    cfgWrite(2, 12, 2, 0, 0, 0);
    writeWord(2, 16'h0888, 0);
    for (int i = 0; i < 100 && csN == 4'b1101; i++) @(negedge clk);
    check(csN == 4'b1011, "R8 new slave only", csN, 4'b1011);
    waitEmpty();
    check(csN == 4'hF, "R4 released after unheld slave", csN, 4'hF);

    // R5/R6 back-to-back and idle-separated words, same slave, divider 1, odd length
    cfgWrite(0, 9, 1, 0, 0, 1);
    slaveSetup(9, 0, 0);
    writeWord(0, 16'h0111, 0);
    @(negedge clk);
    check(txReady == 1'b1, "R5 ready after load", txReady, 1);
    check(txEmpty == 1'b0, "R6 not empty while shifting", txEmpty, 0);
    writeWord(0, 16'h0122, 0);
    check(txReady == 1'b0, "R5 holding full", txReady, 0);
    waitEmpty();
    repeat (10) @(negedge clk);
    writeWord(0, 16'h0133, 0);
    @(negedge clk);
    check(txReady == 1'b1, "R5 ready after idle gap load", txReady, 1);
    waitEmpty();
    writeWord(0, 16'h0144, 1); waitEmpty();
    check(gotQ.size() == 4, "R5 no repeated word", gotQ.size(), 4);
    if (gotQ.size() == 4)
      check(gotQ[0] == 16'h111 && gotQ[1] == 16'h122 && gotQ[2] == 16'h133 && gotQ[3] == 16'h144,
            "R5 word order", gotQ[1], 16'h122);
    check(pulses == 36, "R2 pulses across four words", pulses, 36);
    check(csN == 4'hF, "R4 release at end of run", csN, 4'hF);

    // R11 divider 0 blocks, R5 write while full ignored
    cfgWrite(3, 8, 0, 0, 0, 0);
    slaveSetup(8, 0, 0);
    writeWord(3, 16'h00AA, 0);
    repeat (40) @(negedge clk);
    check(txReady == 1'b0 && txEmpty == 1'b0, "R11 word held", {txReady, txEmpty}, 0);
    check(csN == 4'hF && sclk == 1'b0, "R11 no activity", csN, 4'hF);
    txData = 32'h0000_0055; txWe = 1; @(negedge clk); txWe = 0;
    cfgWrite(3, 8, 3, 0, 0, 0);
    waitEmpty();
    check(gotQ.size() == 1, "R5 ignored write count", gotQ.size(), 1);
    if (gotQ.size() == 1) check(gotQ[0] == 16'h00AA, "R5 ignored write data", gotQ[0], 16'hAA);

    // R10 high polarity: one unchecked word to move the idle level
    for (int i = 0; i < 4; i++) cfgWrite(i, 8, 1, 1, 0, 0);
    slaveEn = 0;
    writeWord(0, 16'h0000, 0); waitEmpty();
    check(sclk == 1'b1, "R10 high idle level", sclk, 1);
    slaveEn = 1;

    // random words with high polarity, both phases
    for (int n = 0; n < 24; n++) begin
      int cs = $urandom_range(3, 0);
      int b  = $urandom_range(16, 8);
      int dv = $urandom_range(4, 1);
      bit ph = 1'($urandom_range(1, 0));
      oneWord(cs, b, dv, 1, ph, 16'($urandom()), ph ? "rand cpha1 R10" : "rand cpha0 R10");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule